// File: doc/BRIEF.md
# I2C Slave Clock-Stretch Controller

This block sits beside the bit engine of an I2C slave. It decides, each time the slave was just addressed or a byte has just crossed the bus, whether the slave must keep the serial clock low. While the clock is low after the acknowledge slot, it looks at the transfer direction and the holding registers. In transmit mode the transmit holding register must hold a fresh byte. In receive mode the receive holding register must be free to take the byte sitting in the shifter. When stretching is enabled, a missing byte or a full register makes the block hold the clock until the condition clears. When stretching is disabled, the block never stalls the bus. It resends the stale transmit byte and flags an underrun, or it drops the received byte and flags an overrun.

There is a second, separate hold that follows the address phase. When it is enabled and any address-match status bit is set, the clock stays low until software has cleared every match bit. The block then goes on to the normal data check. Its outputs are a hold request for the clock pad, a one-cycle strobe telling the shifter to send (with a select for the stale byte), one-cycle strobes to accept or drop a received byte, and two sticky error flags cleared by write-one strobes.

Top module: `clk_stretch_ctrl`

## Requirements
- R1: After reset `hold_scl`, `tx_go`, `tx_resend_stale`, `rx_accept`, `rx_discard`, `urun_flag` and `orun_flag` are all 0.
- R2: The stretch-enable input is 1 and transmit mode is set (`mode_tx`=1). A byte-done event then arrives with `thr_valid`=0. From the next cycle `hold_scl` is 1 and stays 1 while `thr_valid` remains 0, with no send strobe and no underrun.
- R3: The stretch-enable input is 1 and receive mode is set (`mode_tx`=0). A byte-done event then arrives with `rhr_full`=1. From the next cycle `hold_scl` is 1 and stays 1 while `rhr_full` remains 1, with no accept, no discard and no overrun.
- R4: Stretch-on-match is 1 and an address-done event arrives while any `match_bits` bit is 1. From the next cycle `hold_scl` is 1. It stays 1 while at least one match bit is set, and it falls once all bits are 0 (receive mode).
- R5: A stretch ends at the first clock edge that samples the blocking condition cleared. In that cycle `hold_scl` is 0 and the matching strobe pulses: `tx_go` with `tx_resend_stale`=0, or `rx_accept`.
- R6: With stretch enable 0, a transmit byte-done event with `thr_valid`=0 gives no hold. In the next cycle it gives `tx_go`=1 with `tx_resend_stale`=1 and sets `urun_flag`.
- R7: With stretch enable 0, a receive byte-done event with `rhr_full`=1 gives no hold and no `rx_accept`. In the next cycle it gives `rx_discard`=1 and sets `orun_flag`.
- R8: When the holding register is ready (`thr_valid`=1 in transmit mode, `rhr_full`=0 in receive mode), a byte-done event gives no hold. It gives a single strobe in the next cycle: `tx_go` with stale select 0, or `rx_accept`. The stretch enable does not change this.
- R9: The error flags are sticky until a write-one clear on `flag_clr` (bit 0 clears underrun, bit 1 clears overrun). A clear of one flag leaves the other untouched. A new error arriving in the same cycle as its clear leaves the flag set.
- R10: `hold_scl` only rises at an edge where `scl_low` was 1. A stretch requested while `scl_low` is 0 shows up on `hold_scl` one cycle after `scl_low` returns to 1.
- R11: When stretch-on-match is 0, an address-done event gives no address hold, even if match bits are set. In transmit mode with `thr_valid`=1 it leads straight to a `tx_go` strobe in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_low | input | 1 | Serial clock line is currently low |
| mode_tx | input | 1 | 1 = slave transmits, 0 = slave receives |
| evt_addr_done | input | 1 | One-cycle pulse: address phase acknowledged, clock low |
| evt_byte_done | input | 1 | One-cycle pulse: data byte and acknowledge done, clock low |
| thr_valid | input | 1 | Transmit holding register has a fresh byte |
| rhr_full | input | 1 | Receive holding register still occupied |
| match_bits | input | NUM_MATCH | Address-match status bits, cleared by software |
| cfg_stretch_en | input | 1 | Allow stretching on empty/full holding registers |
| cfg_stretch_on_match | input | 1 | Hold clock after address match until match bits cleared |
| flag_clr | input | 2 | Write-one clear: bit 0 underrun, bit 1 overrun |
| hold_scl | output | 1 | Request to keep the serial clock low |
| tx_go | output | 1 | One-cycle strobe: shifter may send a byte |
| tx_resend_stale | output | 1 | With tx_go: resend the old holding-register byte |
| rx_accept | output | 1 | One-cycle strobe: move shifter byte into receive register |
| rx_discard | output | 1 | One-cycle strobe: drop the shifter byte |
| urun_flag | output | 1 | Sticky transmit underrun |
| orun_flag | output | 1 | Sticky receive overrun |

## Verification
The bench builds the block with four address-match bits. This allows two bits to be set at once and then cleared one at a time, so the check can show that a partial clear keeps the address hold in place and only the last clear releases it. The underrun and overrun flags are two separate bits of the clear strobe. This lets the bench clear one flag and confirm that the other stays set, and also hit the case where a set and a clear land in the same cycle.

// File: rtl/cs_pkg.sv
// Package: shared types for the clock-stretch controller.
// Assumes: used by all cs_* modules and clk_stretch_ctrl.
package cs_pkg;

    // Controller states: idle, parked after address match, parked on data.
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_ADDR_HOLD = 2'd1,
        ST_TX_WAIT   = 2'd2,
        ST_RX_WAIT   = 2'd3
    } cs_state_e;

    // One-cycle actions decided for a byte slot.
    typedef struct packed {
        logic go;
        logic stale;
        logic accept;
        logic discard;
        logic set_urun;
        logic set_orun;
    } cs_action_t;

    localparam int FLAG_URUN = 0;
    localparam int FLAG_ORUN = 1;
    localparam int NUM_FLAGS = 2;

endpackage

// File: rtl/cs_decide.sv
// Module: cs_decide
// Decides what happens at a data slot from the direction, the holding
// register states and the stretch enable. It either parks the controller
// in a wait state or produces an immediate action.
// Assumes: evaluated only while the serial clock is low after a byte or
// address phase; purely combinational.
module cs_decide
    import cs_pkg::*;
(
    input  logic       mode_tx,
    input  logic       thr_valid,
    input  logic       rhr_full,
    input  logic       stretch_en,
    output cs_state_e  park,
    output cs_action_t act
);

    // Slot decision: send, accept, stall, or fall back to underrun/overrun.
    always_comb begin
        park = ST_IDLE;
        act  = '0;
        if (mode_tx) begin
            if (thr_valid) begin
                act.go = 1'b1;
            end else if (stretch_en) begin
                park = ST_TX_WAIT;
            end else begin
                act.go       = 1'b1;
                act.stale    = 1'b1;
                act.set_urun = 1'b1;
            end
        end else begin
            if (!rhr_full) begin
                act.accept = 1'b1;
            end else if (stretch_en) begin
                park = ST_RX_WAIT;
            end else begin
                act.discard  = 1'b1;
                act.set_orun = 1'b1;
            end
        end
    end

endmodule

// File: rtl/cs_hold_reg.sv
// Module: cs_hold_reg
// Registered clock-hold request. The hold may only start while the line
// is already low; once asserted it stays until the request goes away.
// Being a flop output, it never glitches.
// Assumes: want_hold comes from next-state logic of the controller.
module cs_hold_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic want_hold,
    input  logic scl_low,
    output logic hold_scl
);

    // Hold flop: start only on a low line, keep while requested.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_scl <= 1'b0;
        end else begin
            hold_scl <= want_hold && (hold_scl || scl_low);
        end
    end

    AST_HOLD_RISE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_scl) |-> $past(scl_low)); // R10

endmodule

// File: rtl/cs_sticky_flags.sv
// Module: cs_sticky_flags
// Bank of sticky status flags with write-one-to-clear. A set in the same
// cycle as a clear wins, so no event is lost.
// Assumes: set and clr are single-cycle strobes in the clk domain.
module cs_sticky_flags #(
    parameter int NFLAG = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] set,
    input  logic [NFLAG-1:0] clr,
    output logic [NFLAG-1:0] flags
);

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        // One flag: set has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags[g] <= 1'b0;
            end else if (set[g]) begin
                flags[g] <= 1'b1;
            end else if (clr[g]) begin
                flags[g] <= 1'b0;
            end
        end

        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[g] && !clr[g]) |=> flags[g]); // R9
        AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set[g] |=> flags[g]); // R9
    end

endmodule

// File: rtl/clk_stretch_ctrl.sv
// Module: clk_stretch_ctrl (top)
// Decides, after each address phase and data byte, whether the I2C slave
// holds the serial clock low. It also issues the send / accept / discard
// strobes and keeps sticky underrun and overrun flags.
// Assumes: events arrive as one-cycle pulses while the clock is low; the
// bit engine, START/STOP detection and registers live elsewhere.
module clk_stretch_ctrl
    import cs_pkg::*;
#(
    parameter int NUM_MATCH = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_low,
    input  logic                 mode_tx,
    input  logic                 evt_addr_done,
    input  logic                 evt_byte_done,
    input  logic                 thr_valid,
    input  logic                 rhr_full,
    input  logic [NUM_MATCH-1:0] match_bits,
    input  logic                 cfg_stretch_en,
    input  logic                 cfg_stretch_on_match,
    input  logic [NUM_FLAGS-1:0] flag_clr,
    output logic                 hold_scl,
    output logic                 tx_go,
    output logic                 tx_resend_stale,
    output logic                 rx_accept,
    output logic                 rx_discard,
    output logic                 urun_flag,
    output logic                 orun_flag
);

    cs_state_e            state, nxt;
    cs_state_e            dec_park;
    cs_action_t           dec_act, act;
    logic                 any_match;
    logic [NUM_FLAGS-1:0] flag_set, flag_q;

    assign any_match = |match_bits;

    cs_decide u_decide (
        .mode_tx    (mode_tx),
        .thr_valid  (thr_valid),
        .rhr_full   (rhr_full),
        .stretch_en (cfg_stretch_en),
        .park       (dec_park),
        .act        (dec_act)
    );

    // Next-state and action selection for the stretch controller.
    always_comb begin
        nxt = state;
        act = '0;
        case (state)
            ST_IDLE: begin
                if (evt_addr_done) begin
                    if (cfg_stretch_on_match && any_match) begin
                        nxt = ST_ADDR_HOLD;
                    end else if (mode_tx) begin
                        nxt = dec_park;
                        act = dec_act;
                    end
                end else if (evt_byte_done) begin
                    nxt = dec_park;
                    act = dec_act;
                end
            end
            ST_ADDR_HOLD: begin
                if (!any_match) begin
                    if (mode_tx) begin
                        nxt = dec_park;
                        act = dec_act;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
            end
            ST_TX_WAIT: begin
                if (thr_valid) begin
                    act.go = 1'b1;
                    nxt    = ST_IDLE;
                end
            end
            ST_RX_WAIT: begin
                if (!rhr_full) begin
                    act.accept = 1'b1;
                    nxt        = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Registered one-cycle strobes to the shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_go           <= 1'b0;
            tx_resend_stale <= 1'b0;
            rx_accept       <= 1'b0;
            rx_discard      <= 1'b0;
        end else begin
            tx_go           <= act.go;
            tx_resend_stale <= act.stale;
            rx_accept       <= act.accept;
            rx_discard      <= act.discard;
        end
    end

    cs_hold_reg u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .want_hold (nxt != ST_IDLE),
        .scl_low   (scl_low),
        .hold_scl  (hold_scl)
    );

    always_comb begin
        flag_set            = '0;
        flag_set[FLAG_URUN] = act.set_urun;
        flag_set[FLAG_ORUN] = act.set_orun;
    end

    cs_sticky_flags #(.NFLAG(NUM_FLAGS)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (flag_set),
        .clr   (flag_clr),
        .flags (flag_q)
    );

    assign urun_flag = flag_q[FLAG_URUN];
    assign orun_flag = flag_q[FLAG_ORUN];

    AST_STALE_NEEDS_GO: assert property (@(posedge clk) disable iff (!rst_n)
        tx_resend_stale |-> tx_go); // R6
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({tx_go, rx_accept, rx_discard}) <= 1); // R8
    AST_DISCARD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_discard |-> orun_flag); // R7
    AST_ADDR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_HOLD && any_match) |=> state == ST_ADDR_HOLD); // R4
    AST_TX_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TX_WAIT && !thr_valid) |=> (state == ST_TX_WAIT && !tx_go)); // R2
    AST_RX_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RX_WAIT && rhr_full) |=> (state == ST_RX_WAIT && !rx_discard)); // R3

endmodule

// File: tb/test_clk_stretch_ctrl.sv
module test_clk_stretch_ctrl;

    localparam int NM = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          scl_low, mode_tx, evt_addr_done, evt_byte_done;
    logic          thr_valid, rhr_full, sen, som;
    logic [NM-1:0] match_bits;
    logic [1:0]    flag_clr;
    logic          hold_scl, tx_go, tx_resend_stale, rx_accept, rx_discard;
    logic          urun_flag, orun_flag;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    clk_stretch_ctrl #(.NUM_MATCH(NM)) i_clk_stretch_ctrl (
        .clk(clk), .rst_n(rst_n), .scl_low(scl_low), .mode_tx(mode_tx),
        .evt_addr_done(evt_addr_done), .evt_byte_done(evt_byte_done),
        .thr_valid(thr_valid), .rhr_full(rhr_full), .match_bits(match_bits),
        .cfg_stretch_en(sen), .cfg_stretch_on_match(som), .flag_clr(flag_clr),
        .hold_scl(hold_scl), .tx_go(tx_go), .tx_resend_stale(tx_resend_stale),
        .rx_accept(rx_accept), .rx_discard(rx_discard),
        .urun_flag(urun_flag), .orun_flag(orun_flag)
    );

    // Vector fields: tx thr rhr sen | hold go stale acc disc urun orun
    localparam logic [10:0] VEC [8] = '{
        11'b1101_0100000, // R8 tx ready, stretch on
        11'b1001_1000000, // R2 tx empty, stretch on
        11'b1000_0110010, // R6 tx empty, stretch off
        11'b1100_0100000, // R8 tx ready, stretch off
        11'b0001_0001000, // R8 rx free, stretch on
        11'b0011_1000000, // R3 rx full, stretch on
        11'b0010_0000101, // R7 rx full, stretch off
        11'b0000_0001000  // R8 rx free, stretch off
    };

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic pulse_byte();
        evt_byte_done = 1'b1;
        step();
        evt_byte_done = 1'b0;
    endtask

    task automatic cleanup();
        thr_valid = 1'b1;
        rhr_full  = 1'b0;
        step();
        step();
        flag_clr = 2'b11;
        step();
        flag_clr = 2'b00;
        step();
    endtask

    initial begin
        #1500000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; scl_low = 1'b1; mode_tx = 1'b0;
        evt_addr_done = 1'b0; evt_byte_done = 1'b0;
        thr_valid = 1'b0; rhr_full = 1'b0; sen = 1'b0; som = 1'b0;
        match_bits = '0; flag_clr = 2'b00;
        step(); step(); step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 hold", hold_scl, 1'b0);
        chk("R1 go", tx_go, 1'b0);
        chk("R1 stale", tx_resend_stale, 1'b0);
        chk("R1 accept", rx_accept, 1'b0);
        chk("R1 discard", rx_discard, 1'b0);
        chk("R1 urun", urun_flag, 1'b0);
        chk("R1 orun", orun_flag, 1'b0);

        // Table walk (R2 R3 R6 R7 R8)
        foreach (VEC[i]) begin
            mode_tx   = VEC[i][10];
            thr_valid = VEC[i][9];
            rhr_full  = VEC[i][8];
            sen       = VEC[i][7];
            pulse_byte();
            chk($sformatf("vec%0d hold", i),    hold_scl,        VEC[i][6]);
            chk($sformatf("vec%0d go", i),      tx_go,           VEC[i][5]);
            chk($sformatf("vec%0d stale", i),   tx_resend_stale, VEC[i][4]);
            chk($sformatf("vec%0d accept", i),  rx_accept,       VEC[i][3]);
            chk($sformatf("vec%0d discard", i), rx_discard,      VEC[i][2]);
            chk($sformatf("vec%0d urun", i),    urun_flag,       VEC[i][1]);
            chk($sformatf("vec%0d orun", i),    orun_flag,       VEC[i][0]);
            cleanup();
        end

        // R2 / R5 transmit stretch persists, then releases with a fresh send
        mode_tx = 1'b1; sen = 1'b1; thr_valid = 1'b0;
        pulse_byte();
        step(); step();
        chk("R2 hold kept", hold_scl, 1'b1);
        chk("R2 no go", tx_go, 1'b0);
        thr_valid = 1'b1;
        step();
        chk("R5 tx hold released", hold_scl, 1'b0);
        chk("R5 tx go", tx_go, 1'b1);
        chk("R5 tx fresh", tx_resend_stale, 1'b0);
        step();
        chk("R5 tx go one cycle", tx_go, 1'b0);

        // R3 / R5 receive stretch persists, then releases with accept
        mode_tx = 1'b0; rhr_full = 1'b1;
        pulse_byte();
        step();
        chk("R3 hold kept", hold_scl, 1'b1);
        chk("R3 no discard", rx_discard, 1'b0);
        rhr_full = 1'b0;
        step();
        chk("R5 rx hold released", hold_scl, 1'b0);
        chk("R5 rx accept", rx_accept, 1'b1);
        cleanup();

        // R4 address-match hold, partial clear keeps it
        mode_tx = 1'b0; som = 1'b1; match_bits = 4'b0101;
        evt_addr_done = 1'b1; step(); evt_addr_done = 1'b0;
        chk("R4 hold on match", hold_scl, 1'b1);
        match_bits = 4'b0100;
        step();
        chk("R4 partial clear holds", hold_scl, 1'b1);
        match_bits = 4'b0000;
        step();
        chk("R4 full clear releases", hold_scl, 1'b0);
        som = 1'b0;
        cleanup();

        // R11 no address hold when disabled; transmit proceeds
        mode_tx = 1'b1; thr_valid = 1'b1; match_bits = 4'b0010;
        evt_addr_done = 1'b1; step(); evt_addr_done = 1'b0;
        chk("R11 no hold", hold_scl, 1'b0);
        chk("R11 go", tx_go, 1'b1);
        match_bits = '0;
        cleanup();

        // R10 hold waits for a low line
        mode_tx = 1'b1; sen = 1'b1; thr_valid = 1'b0; scl_low = 1'b0;
        pulse_byte();
        chk("R10 no hold while high", hold_scl, 1'b0);
        scl_low = 1'b1;
        step();
        chk("R10 hold after low", hold_scl, 1'b1);
        cleanup();

        // R9 sticky flags, selective clear, set beats clear
        sen = 1'b0; mode_tx = 1'b1; thr_valid = 1'b0;
        pulse_byte();
        mode_tx = 1'b0; rhr_full = 1'b1;
        pulse_byte();
        rhr_full = 1'b0;
        step(); step(); step();
        chk("R9 urun sticky", urun_flag, 1'b1);
        chk("R9 orun sticky", orun_flag, 1'b1);
        flag_clr = 2'b10;
        step();
        flag_clr = 2'b00;
        chk("R9 orun cleared", orun_flag, 1'b0);
        chk("R9 urun untouched", urun_flag, 1'b1);
        flag_clr = 2'b01;
        step();
        flag_clr = 2'b00;
        chk("R9 urun cleared", urun_flag, 1'b0);
        mode_tx = 1'b1; thr_valid = 1'b0; flag_clr = 2'b01;
        pulse_byte();
        flag_clr = 2'b00;
        chk("R9 set wins over clear", urun_flag, 1'b1);
        cleanup();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule